// File: doc/BRIEF.md
# Nibble Bit-Test and Rotate Execution Unit

This unit executes the single-bit and rotate instructions of a 4-bit core. It can set or clear one bit of the data-memory nibble at the current pointer. It can copy a bit of that nibble, or of the accumulator, into the status flag. It rotates the accumulator, the X pointer or the Y pointer through the carry flag. A bank flag picks whether the primary pointers or their alternate copies are rotated. The unit also executes the opcodes that set or clear carry and the bank flag, as well as the no-operation and halt opcodes.

The unit holds the carry, status, bank and halt flags. The accumulator and the four pointer registers live in the surrounding register file. The unit reads their current values and returns at most one write strobe with its data. Memory access is a read-modify-write port: the addressed nibble comes in, and a write strobe and new data go out in the same cycle. Address generation belongs to the caller. After a halt, the unit ignores opcodes until `wake` is raised or a reset occurs.

Top module: `bitrot_unit`

## Requirements
- R1: After reset, carry, status, bank and halted are all 0.
- R2: Opcodes 0x30..0x33 write the memory nibble with bit b set, where b is opcode[1:0]. Opcodes 0x34..0x37 write it with bit b cleared. Both kinds set status to 1 and leave carry unchanged.
- R3: Opcodes 0x38..0x3B copy bit opcode[1:0] of the memory nibble into status and do not write memory.
- R4: Opcodes 0x3C..0x3F copy bit opcode[1:0] of the accumulator into status and write nothing.
- R5: 0x21 rotates the accumulator right through carry: the old carry enters b3 and b0 becomes the new carry. 0x22 rotates it left: the old carry enters b0 and b3 becomes the new carry. After any rotate, status equals the new carry. Register strobe bits are rf_we_o[0]=accumulator, [1]=X, [2]=X', [3]=Y and [4]=Y'.
- R6: 0x24 and 0x25 rotate Y right and left. 0x28 and 0x29 rotate X right and left. With bank=1 the alternate register (Y' or X') is the target instead.
- R7: 0x0C sets carry and 0x1C clears it. 0x10 sets bank and 0x20 clears it. 0x00 does nothing else. Each of these opcodes sets status to 1.
- R8: An opcode with op_valid low, or any opcode not listed here, changes no flag and writes neither memory nor registers.
- R9: 0x07 sets halted and sets status to 1. While halted, opcodes change no flag and raise no write strobe.
- R10: While halted, wake clears halted at the next edge. An opcode presented in that same cycle is dropped.
- R11: At most one register write strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode present this cycle |
| op_code | input | 8 | Opcode |
| wake | input | 1 | Leave the halted state |
| acc_i | input | 4 | Current accumulator |
| x_i | input | 4 | Current X |
| xa_i | input | 4 | Current X' |
| y_i | input | 4 | Current Y |
| ya_i | input | 4 | Current Y' |
| mem_rd_i | input | 4 | Nibble at the current pointer |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wd_o | output | 4 | Memory write data |
| rf_we_o | output | 5 | Register write strobes (see R5) |
| rf_wd_o | output | 4 | Register write data |
| carry_o | output | 1 | Carry flag |
| status_o | output | 1 | Status flag |
| bank_o | output | 1 | Bank-select flag |
| halted_o | output | 1 | Halted state |

## Verification
Two events can fall in the same cycle: leaving the halted state and an incoming opcode. The bench holds the unit halted, then raises `wake` together with a valid carry-set opcode. It expects halted to drop at the next edge while carry stays unchanged, and it expects the same opcode issued one cycle later to take effect. A second overlap occurs when a rotate consumes the old carry in the same edge that writes the new one. The vectors build the carry with one opcode and rotate with the next, then judge both the rotated data and the carry that comes out.

// File: rtl/bitrot_pkg.sv
package bitrot_pkg;

   typedef enum logic [3:0] {
      K_NONE, K_SET, K_CLR, K_TMEM, K_TACC, K_ROT,
      K_CSET, K_CCLR, K_BSET, K_BCLR, K_NOP, K_HALT
   } kind_e;

   typedef enum logic [1:0] {
      G_ACC, G_Y, G_X
   } tgt_e;

   typedef struct packed {
      kind_e      kind;
      tgt_e       tgt;
      logic       left;
      logic [1:0] bsel;
   } dec_t;

   localparam int RF_ACC = 0;
   localparam int RF_X   = 1;
   localparam int RF_XA  = 2;
   localparam int RF_Y   = 3;
   localparam int RF_YA  = 4;
   localparam int RF_N   = 5;

endpackage

// File: rtl/bitrot_decode.sv
module bitrot_decode
   import bitrot_pkg::*;
#(
   parameter int OP_W    = 8,
   parameter bit HALT_EN = 1'b1
) (
   input  logic [OP_W-1:0] op,
   output dec_t            dec
);

   always_comb begin
      dec      = '0;
      dec.kind = K_NONE;
      dec.tgt  = G_ACC;
      dec.bsel = op[1:0];
      casez (op[7:0])
         8'b0011_00??: dec.kind = K_SET;
         8'b0011_01??: dec.kind = K_CLR;
         8'b0011_10??: dec.kind = K_TMEM;
         8'b0011_11??: dec.kind = K_TACC;
         8'h21: begin dec.kind = K_ROT; dec.tgt = G_ACC; dec.left = 1'b0; end
         8'h22: begin dec.kind = K_ROT; dec.tgt = G_ACC; dec.left = 1'b1; end
         8'h24: begin dec.kind = K_ROT; dec.tgt = G_Y;   dec.left = 1'b0; end
         8'h25: begin dec.kind = K_ROT; dec.tgt = G_Y;   dec.left = 1'b1; end
         8'h28: begin dec.kind = K_ROT; dec.tgt = G_X;   dec.left = 1'b0; end
         8'h29: begin dec.kind = K_ROT; dec.tgt = G_X;   dec.left = 1'b1; end
         8'h0C: dec.kind = K_CSET;
         8'h1C: dec.kind = K_CCLR;
         8'h10: dec.kind = K_BSET;
         8'h20: dec.kind = K_BCLR;
         8'h00: dec.kind = K_NOP;
         8'h07: dec.kind = HALT_EN ? K_HALT : K_NONE;
         default: dec.kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/bitrot_datapath.sv
module bitrot_datapath
   import bitrot_pkg::*;
#(
   parameter int W = 4
) (
   input  logic          go,
   input  dec_t          dec,
   input  logic          carry,
   input  logic          bank,
   input  logic [W-1:0]  acc,
   input  logic [W-1:0]  x,
   input  logic [W-1:0]  xa,
   input  logic [W-1:0]  y,
   input  logic [W-1:0]  ya,
   input  logic [W-1:0]  mem_rd,
   output logic          mem_we,
   output logic [W-1:0]  mem_wd,
   output logic [RF_N-1:0] rf_we,
   output logic [W-1:0]  rf_wd,
   output logic          cout,
   output logic          tst_bit
);

   logic [W-1:0] src;
   logic [W-1:0] mask;
   logic [W-1:0] rot_r;
   logic [W-1:0] rot_l;

   genvar gi;
   generate
      for (gi = 0; gi < W; gi++) begin : g_mask
         assign mask[gi] = (dec.bsel == gi[1:0]);
      end
      for (gi = 0; gi < W - 1; gi++) begin : g_rot
         assign rot_r[gi]     = src[gi+1];
         assign rot_l[gi+1]   = src[gi];
      end
   endgenerate
   assign rot_r[W-1] = carry;
   assign rot_l[0]   = carry;

   always_comb begin
      unique case (dec.tgt)
         G_Y:     src = bank ? ya : y;
         G_X:     src = bank ? xa : x;
         default: src = acc;
      endcase
   end

   assign cout    = dec.left ? src[W-1] : src[0];
   assign tst_bit = (dec.kind == K_TMEM) ? |(mem_rd & mask) : |(acc & mask);

   always_comb begin
      rf_we = '0;
      rf_wd = dec.left ? rot_l : rot_r;
      if (go && dec.kind == K_ROT) begin
         unique case (dec.tgt)
            G_Y:     rf_we[bank ? RF_YA : RF_Y] = 1'b1;
            G_X:     rf_we[bank ? RF_XA : RF_X] = 1'b1;
            default: rf_we[RF_ACC] = 1'b1;
         endcase
      end
   end

   assign mem_we = go && (dec.kind == K_SET || dec.kind == K_CLR);
   assign mem_wd = (dec.kind == K_SET) ? (mem_rd | mask) : (mem_rd & ~mask);

endmodule

// File: rtl/bitrot_flags.sv
module bitrot_flags
   import bitrot_pkg::*;
#(
   parameter bit HALT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic wake,
   input  dec_t dec,
   input  logic cout,
   input  logic tst_bit,
   output logic carry,
   output logic status,
   output logic bank,
   output logic halted
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry  <= 1'b0;
         status <= 1'b0;
         bank   <= 1'b0;
      end else if (go) begin
         unique case (dec.kind)
            K_SET, K_CLR:   status <= 1'b1;
            K_TMEM, K_TACC: status <= tst_bit;
            K_ROT:  begin carry <= cout; status <= cout; end
            K_CSET: begin carry <= 1'b1; status <= 1'b1; end
            K_CCLR: begin carry <= 1'b0; status <= 1'b1; end
            K_BSET: begin bank  <= 1'b1; status <= 1'b1; end
            K_BCLR: begin bank  <= 1'b0; status <= 1'b1; end
            K_NOP, K_HALT:  status <= 1'b1;
            default: ;
         endcase
      end
   end

   generate
      if (HALT_EN) begin : g_halt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               halted <= 1'b0;
            else if (halted && wake)
               halted <= 1'b0;
            else if (go && dec.kind == K_HALT)
               halted <= 1'b1;
         end
      end else begin : g_nohalt
         assign halted = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bitrot_unit.sv
module bitrot_unit
   import bitrot_pkg::*;
#(
   parameter int W       = 4,
   parameter int OP_W    = 8,
   parameter bit HALT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic              wake,
   input  logic [W-1:0]      acc_i,
   input  logic [W-1:0]      x_i,
   input  logic [W-1:0]      xa_i,
   input  logic [W-1:0]      y_i,
   input  logic [W-1:0]      ya_i,
   input  logic [W-1:0]      mem_rd_i,
   output logic              mem_we_o,
   output logic [W-1:0]      mem_wd_o,
   output logic [RF_N-1:0]   rf_we_o,
   output logic [W-1:0]      rf_wd_o,
   output logic              carry_o,
   output logic              status_o,
   output logic              bank_o,
   output logic              halted_o
);

   localparam int BIT_IDX_W = $clog2(W);

   generate
      if (W != 4 || BIT_IDX_W != 2) begin : g_bad_w
         $error("bitrot_unit: W must be 4, the bit field is opcode[1:0]");
      end
      if (OP_W != 8) begin : g_bad_op
         $error("bitrot_unit: OP_W must be 8");
      end
   endgenerate

   dec_t dec;
   logic go;
   logic cout;
   logic tst_bit;

   assign go = op_valid && !halted_o;

   bitrot_decode #(.OP_W(OP_W), .HALT_EN(HALT_EN)) u_dec (
      .op  (op_code),
      .dec (dec)
   );

   bitrot_datapath #(.W(W)) u_dp (
      .go      (go),
      .dec     (dec),
      .carry   (carry_o),
      .bank    (bank_o),
      .acc     (acc_i),
      .x       (x_i),
      .xa      (xa_i),
      .y       (y_i),
      .ya      (ya_i),
      .mem_rd  (mem_rd_i),
      .mem_we  (mem_we_o),
      .mem_wd  (mem_wd_o),
      .rf_we   (rf_we_o),
      .rf_wd   (rf_wd_o),
      .cout    (cout),
      .tst_bit (tst_bit)
   );

   bitrot_flags #(.HALT_EN(HALT_EN)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .wake    (wake),
      .dec     (dec),
      .cout    (cout),
      .tst_bit (tst_bit),
      .carry   (carry_o),
      .status  (status_o),
      .bank    (bank_o),
      .halted  (halted_o)
   );

endmodule

// File: rtl/bitrot_unit_chk.sv
module bitrot_unit_chk #(
   parameter int W    = 4,
   parameter int OP_W = 8,
   parameter int NWE  = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [OP_W-1:0] op_code,
   input logic            wake,
   input logic            mem_we_o,
   input logic [W-1:0]    mem_wd_o,
   input logic [NWE-1:0]  rf_we_o,
   input logic            carry_o,
   input logic            status_o,
   input logic            bank_o,
   input logic            halted_o
);

   logic issue;
   assign issue = op_valid && !halted_o;

   assert_onehot_we_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rf_we_o));

   assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> (rf_we_o == '0 && !mem_we_o));

   assert_halt_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_code == 8'h07) |=> halted_o);

   assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && wake) |=> !halted_o);

   assert_rot_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (op_code == 8'h21 || op_code == 8'h22)) |=> (status_o == carry_o));

   assert_setbit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_code[7:2] == 6'b001100) |-> (mem_we_o && mem_wd_o[op_code[1:0]]));

   assert_tmem_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op_code[7:2] == 6'b001110) |-> !mem_we_o);

   assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !halted_o) |=> ($stable(carry_o) && $stable(bank_o) && $stable(status_o)));

endmodule

bind bitrot_unit bitrot_unit_chk #(.W(W), .OP_W(OP_W), .NWE(bitrot_pkg::RF_N)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .wake     (wake),
   .mem_we_o (mem_we_o),
   .mem_wd_o (mem_wd_o),
   .rf_we_o  (rf_we_o),
   .carry_o  (carry_o),
   .status_o (status_o),
   .bank_o   (bank_o),
   .halted_o (halted_o)
);

// File: tb/bitrot_unit_bench.sv
`timescale 1ns/1ps
module bitrot_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] op_code = '0;
   logic       wake = 1'b0;
   logic [3:0] acc_i = '0, x_i = '0, xa_i = '0, y_i = '0, ya_i = '0, mem_rd_i = '0;
   logic       mem_we_o;
   logic [3:0] mem_wd_o;
   logic [4:0] rf_we_o;
   logic [3:0] rf_wd_o;
   logic       carry_o, status_o, bank_o, halted_o;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   bitrot_unit u_bitrot_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .wake(wake),
      .acc_i(acc_i), .x_i(x_i), .xa_i(xa_i), .y_i(y_i), .ya_i(ya_i), .mem_rd_i(mem_rd_i),
      .mem_we_o(mem_we_o), .mem_wd_o(mem_wd_o), .rf_we_o(rf_we_o), .rf_wd_o(rf_wd_o),
      .carry_o(carry_o), .status_o(status_o), .bank_o(bank_o), .halted_o(halted_o)
   );

   typedef struct packed {
      logic [7:0] op;
      logic [3:0] acc, x, xa, y, ya, mem;
      logic [4:0] we;
      logic [3:0] wd;
      logic       mwe;
      logic [3:0] mwd;
      logic       c, st, bk;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{8'h0C, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0},
      '{8'h21, 4'h6, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00001, 4'hB, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h22, 4'h9, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00001, 4'h2, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0},
      '{8'h24, 4'h0, 4'h0, 4'h0, 4'h4, 4'h3, 4'h0, 5'b01000, 4'hA, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h10, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1},
      '{8'h25, 4'h0, 4'h0, 4'h0, 4'h3, 4'hC, 4'h0, 5'b10000, 4'h8, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      '{8'h28, 4'h0, 4'hF, 4'h3, 4'h0, 4'h0, 4'h0, 5'b00100, 4'h9, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      '{8'h20, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0},
      '{8'h29, 4'h0, 4'h5, 4'hE, 4'h0, 4'h0, 4'h0, 5'b00010, 4'hB, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h31, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h4, 5'b00000, 4'h0, 1'b1, 4'h6, 1'b0, 1'b1, 1'b0},
      '{8'h37, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 5'b00000, 4'h0, 1'b1, 4'h7, 1'b0, 1'b1, 1'b0},
      '{8'h3A, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'hB, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h38, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
      '{8'h3F, 4'h7, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h3D, 4'h2, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
      '{8'h0C, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0},
      '{8'h1C, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
      '{8'h3F, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h55, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      '{8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 5'b00000, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0}
   };

   function automatic string req_of(input logic [7:0] op);
      if (op[7:3] == 5'b00110)                     return "R2";
      if (op[7:2] == 6'b001110)                    return "R3";
      if (op[7:2] == 6'b001111)                    return "R4";
      if (op == 8'h21 || op == 8'h22)              return "R5";
      if (op == 8'h24 || op == 8'h25 || op == 8'h28 || op == 8'h29) return "R6";
      if (op == 8'h0C || op == 8'h1C || op == 8'h10 || op == 8'h20 || op == 8'h00) return "R7";
      return "R8";
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk({carry_o, status_o, bank_o, halted_o} == 4'b0000, "R1", "flags in reset",
          {4'h0, carry_o, status_o, bank_o, halted_o}, 8'h00);
      rst_n = 1'b1;
      tick();
      chk({carry_o, status_o, bank_o, halted_o} == 4'b0000, "R1", "flags after reset",
          {4'h0, carry_o, status_o, bank_o, halted_o}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         string r;
         r = req_of(VEC[i].op);
         op_valid = 1'b1;
         op_code  = VEC[i].op;
         acc_i = VEC[i].acc; x_i = VEC[i].x; xa_i = VEC[i].xa;
         y_i = VEC[i].y; ya_i = VEC[i].ya; mem_rd_i = VEC[i].mem;
         #1;
         chk(rf_we_o == VEC[i].we, r, "rf_we", {3'b0, rf_we_o}, {3'b0, VEC[i].we});
         if (VEC[i].we != '0)
            chk(rf_wd_o == VEC[i].wd, r, "rf_wd", {4'h0, rf_wd_o}, {4'h0, VEC[i].wd});
         chk(mem_we_o == VEC[i].mwe, r, "mem_we", {7'h0, mem_we_o}, {7'h0, VEC[i].mwe});
         if (VEC[i].mwe)
            chk(mem_wd_o == VEC[i].mwd, r, "mem_wd", {4'h0, mem_wd_o}, {4'h0, VEC[i].mwd});
         tick();
         chk({carry_o, status_o, bank_o} == {VEC[i].c, VEC[i].st, VEC[i].bk}, r, "carry/status/bank",
             {5'h0, carry_o, status_o, bank_o}, {5'h0, VEC[i].c, VEC[i].st, VEC[i].bk});
      end

      // R8: op_valid low ignores a carry-set opcode
      op_valid = 1'b0; op_code = 8'h0C;
      #1;
      chk(rf_we_o == '0 && !mem_we_o, "R8", "strobes with op_valid low",
          {2'b0, mem_we_o, rf_we_o}, 8'h00);
      tick();
      chk(carry_o == 1'b0, "R8", "carry with op_valid low", {7'h0, carry_o}, 8'h00);

      // R9: halt, then opcodes are ignored
      op_valid = 1'b1; op_code = 8'h07;
      tick();
      chk(halted_o && status_o, "R9", "halted/status after halt",
          {6'h0, halted_o, status_o}, 8'h03);
      op_code = 8'h21; acc_i = 4'h5;
      #1;
      chk(rf_we_o == '0, "R9", "rotate strobe while halted", {3'b0, rf_we_o}, 8'h00);
      op_code = 8'h0C;
      tick();
      chk(carry_o == 1'b0 && halted_o, "R9", "carry/halted while halted",
          {6'h0, carry_o, halted_o}, 8'h01);
      op_code = 8'h31; mem_rd_i = 4'h0;
      #1;
      chk(!mem_we_o, "R9", "memory strobe while halted", {7'h0, mem_we_o}, 8'h00);

      // R10: wake and an opcode in the same cycle
      op_code = 8'h0C; wake = 1'b1;
      tick();
      wake = 1'b0;
      chk(!halted_o && carry_o == 1'b0, "R10", "halted/carry after wake cycle",
          {6'h0, halted_o, carry_o}, 8'h00);
      tick();
      chk(carry_o == 1'b1, "R10", "opcode after wake takes effect", {7'h0, carry_o}, 8'h01);

      // R11: bank set, then an X rotate raises only the X' strobe
      op_code = 8'h10;
      tick();
      op_code = 8'h29; x_i = 4'h0; xa_i = 4'h8;
      #1;
      chk(rf_we_o == 5'b00100 && rf_wd_o == 4'h1, "R11", "single strobe X' rotate",
          {rf_we_o[3:0], rf_wd_o}, 8'h41);
      tick();
      chk(carry_o == 1'b1 && status_o == 1'b1, "R6", "carry out of X' left rotate",
          {6'h0, carry_o, status_o}, 8'h03);

      // R1: reset mid-run clears the flags
      op_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk({carry_o, status_o, bank_o, halted_o} == 4'b0000, "R1", "flags after mid-run reset",
          {4'h0, carry_o, status_o, bank_o, halted_o}, 8'h00);
      rst_n = 1'b1;
      tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule